// File: doc/BRIEF.md
# NAND Image Loader with Bad-Block Skipping

This controller copies a contiguous image out of NAND flash into a destination memory. Software-side logic presents a start byte offset into the flash, a length in bytes and a destination base address, then pulses `start`. The loader works out the block and page range from these values. It visits the blocks in ascending order and reads a marker byte from the spare area of each block before it touches that block. Every page of a good block is streamed out through a simple write port. A bad block is stepped over, and the range is pushed one block further so that the requested length still arrives.

The loader does not drive the flash pins itself. It issues commands to a command engine through a request/done handshake. Each command carries a kind, a block, a page and a column. Bytes then come back on a byte stream with a valid strobe. Each page is read in ECC steps. For every step the loader requests the data column for that step and takes the step's data bytes. It then requests the step's ECC column in the spare area and takes the ECC bytes. Those ECC bytes are not written to memory. They appear on a side port, tagged with their step number, for an external corrector.

An offset that is not page aligned is handled by dropping the leading bytes of the first page. The byte at the requested offset therefore lands exactly at the destination base.

Top module: `nand_image_loader`

## Requirements
- R1: After reset `busy`, `done`, `cmd_req`, `wr_valid` and `ecc_valid` are all low, and while idle no command or write is issued.
- R2: Each block visited starts with a command of kind 0 (marker) for page 0 at column PAGE_BYTES+MARK_POS, followed by exactly one stream byte.
- R3: A block whose marker byte is not 0xFF is skipped with no page read, and the last block index grows by one, so the write count equals that of the same range with the bad blocks removed.
- R4: The first block is offset/block_bytes, the last is (offset+length-1)/block_bytes, and the first page read is (offset mod block_bytes)/PAGE_BYTES. A good block is read from the current page through its last page, after which the page index returns to 0. A bad block leaves the page index unchanged.
- R5: The first (offset mod PAGE_BYTES) data bytes of the first page are dropped, and the byte at the offset is written to `dst_base`.
- R6: Each page is read as a command of kind 1 (page open, column 0), then, for steps s=0..STEPS-1, a kind 2 command at column s*ECC_STEP followed by ECC_STEP bytes and a kind 3 command at column PAGE_BYTES+ECC_POS+s*ECC_BYTES followed by ECC_BYTES bytes. A command request is held, with stable fields, until `cmd_done`.
- R7: ECC bytes appear on `ecc_data` with `ecc_valid` and their step index on `ecc_step`, in arrival order. They never appear on the write port, and the two valid strobes are never high together.
- R8: `busy` is high from the cycle after an accepted `start` until the operation ends. `done` is then high for exactly one cycle, with `busy` low.
- R9: Written data equals the flash bytes in block, page and column order, at addresses that increase by one from `dst_base`.

Ports are listed in the order of the port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load (taken while idle) |
| start_offset | input | OFF_W | Flash byte offset of the image |
| start_len | input | OFF_W | Image length in bytes |
| dst_base | input | DST_W | First destination address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-load pulse |
| cmd_req | output | 1 | Command request to the flash engine |
| cmd_kind | output | 2 | 0 marker, 1 page open, 2 data column, 3 ECC column |
| cmd_block | output | OFF_W | Block index of the command |
| cmd_page | output | PG_W | Page within the block |
| cmd_col | output | COL_W | Byte column within the page |
| cmd_done | input | 1 | Command accepted by the engine |
| rd_valid | input | 1 | Stream byte valid |
| rd_data | input | 8 | Stream byte |
| wr_valid | output | 1 | Destination write strobe |
| wr_addr | output | DST_W | Destination address |
| wr_data | output | 8 | Destination byte |
| ecc_valid | output | 1 | ECC byte valid |
| ecc_step | output | STEP_W | ECC step the byte belongs to |
| ecc_data | output | 8 | ECC byte from the spare area |

## Verification
The vector table tries several ranges, and each one separates a different part of the range logic. An aligned single block confirms the basic page and step sequence. A range starting mid-block and spanning two blocks tests the start-page arithmetic and the page index returning to 0. Ranges with bad blocks at the start, in the middle, or in more than one place tell marker skipping and last-block extension apart from a plain overrun. Misaligned offsets, including one where a bad block is followed by a start page other than 0, show whether the leading-byte drop and the page carry-over are kept separate. A final one-byte load at the last page of a block probes the range edge.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_MARK_CMD,
        S_MARK_BYTE,
        S_OPEN_CMD,
        S_DCOL_CMD,
        S_DATA,
        S_ECOL_CMD,
        S_ECC,
        S_NEXT_BLK
    } ldr_state_t;

    typedef enum logic [1:0] {
        K_MARK = 2'd0,
        K_OPEN = 2'd1,
        K_DATA = 2'd2,
        K_ECC  = 2'd3
    } ldr_kind_t;

endpackage

// File: rtl/ldr_span.sv
module ldr_span #(
    parameter int OFF_W      = 24,
    parameter int PAGE_BYTES = 16,
    parameter int BLK_BYTES  = 64,
    parameter int PG_W       = 2,
    parameter int SKIP_W     = 4
) (
    input  logic [OFF_W-1:0]  offset,
    input  logic [OFF_W-1:0]  length,
    output logic [OFF_W-1:0]  first_blk,
    output logic [OFF_W-1:0]  last_blk,
    output logic [PG_W-1:0]   first_page,
    output logic [SKIP_W-1:0] lead_skip
);
    localparam logic [OFF_W-1:0] BLK_L  = OFF_W'(BLK_BYTES);
    localparam logic [OFF_W-1:0] PAGE_L = OFF_W'(PAGE_BYTES);

    logic [OFF_W-1:0] end_off;
    logic [OFF_W-1:0] in_blk;
    logic [OFF_W-1:0] pg_full;
    logic [OFF_W-1:0] sk_full;

    always_comb begin
        end_off    = offset + length - OFF_W'(1);
        first_blk  = offset / BLK_L;
        last_blk   = end_off / BLK_L;
        in_blk     = offset % BLK_L;
        pg_full    = in_blk / PAGE_L;
        sk_full    = offset % PAGE_L;
        first_page = pg_full[PG_W-1:0];
        lead_skip  = sk_full[SKIP_W-1:0];
    end
endmodule

// File: rtl/ldr_colgen.sv
module ldr_colgen
    import ldr_pkg::*;
#(
    parameter int PAGE_BYTES = 16,
    parameter int ECC_STEP   = 8,
    parameter int ECC_BYTES  = 3,
    parameter int ECC_POS    = 1,
    parameter int MARK_POS   = 0,
    parameter int STEP_W     = 1,
    parameter int COL_W      = 5
) (
    input  ldr_kind_t         kind,
    input  logic [STEP_W-1:0] step,
    output logic [COL_W-1:0]  col
);
    always_comb begin
        unique case (kind)
            K_MARK: col = COL_W'(PAGE_BYTES + MARK_POS);
            K_OPEN: col = '0;
            K_DATA: col = COL_W'(step) * COL_W'(ECC_STEP);
            K_ECC:  col = COL_W'(PAGE_BYTES + ECC_POS) + COL_W'(step) * COL_W'(ECC_BYTES);
            default: col = '0;
        endcase
    end
endmodule

// File: rtl/nand_image_loader.sv
module nand_image_loader
    import ldr_pkg::*;
#(
    parameter int OFF_W           = 24,
    parameter int DST_W           = 16,
    parameter int PAGE_BYTES      = 16,
    parameter int SPARE_BYTES     = 8,
    parameter int PAGES_PER_BLOCK = 4,
    parameter int ECC_STEP        = 8,
    parameter int ECC_BYTES       = 3,
    parameter int ECC_POS         = 1,
    parameter int MARK_POS        = 0,
    localparam int STEPS     = PAGE_BYTES / ECC_STEP,
    localparam int BLK_BYTES = PAGE_BYTES * PAGES_PER_BLOCK,
    localparam int PG_W      = (PAGES_PER_BLOCK > 1) ? $clog2(PAGES_PER_BLOCK) : 1,
    localparam int STEP_W    = (STEPS > 1) ? $clog2(STEPS) : 1,
    localparam int COL_W     = $clog2(PAGE_BYTES + SPARE_BYTES),
    localparam int SKIP_W    = $clog2(PAGE_BYTES),
    localparam int CNT_MAX   = (ECC_STEP > ECC_BYTES) ? ECC_STEP : ECC_BYTES,
    localparam int CNT_W     = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OFF_W-1:0]  start_offset,
    input  logic [OFF_W-1:0]  start_len,
    input  logic [DST_W-1:0]  dst_base,
    output logic              busy,
    output logic              done,
    output logic              cmd_req,
    output logic [1:0]        cmd_kind,
    output logic [OFF_W-1:0]  cmd_block,
    output logic [PG_W-1:0]   cmd_page,
    output logic [COL_W-1:0]  cmd_col,
    input  logic              cmd_done,
    input  logic              rd_valid,
    input  logic [7:0]        rd_data,
    output logic              wr_valid,
    output logic [DST_W-1:0]  wr_addr,
    output logic [7:0]        wr_data,
    output logic              ecc_valid,
    output logic [STEP_W-1:0] ecc_step,
    output logic [7:0]        ecc_data
);
    typedef struct packed {
        ldr_state_t        st;
        logic [OFF_W-1:0]  blk;
        logic [OFF_W-1:0]  last;
        logic [PG_W-1:0]   page;
        logic [STEP_W-1:0] step;
        logic [CNT_W-1:0]  cnt;
        logic [SKIP_W-1:0] skip;
        logic [DST_W-1:0]  wptr;
        logic              wr_v;
        logic [DST_W-1:0]  wr_a;
        logic [7:0]        wr_d;
        logic              ecc_v;
        logic [STEP_W-1:0] ecc_s;
        logic [7:0]        ecc_d;
        logic              done;
    } ldr_regs_t;

    ldr_regs_t r_q, r_d;

    logic [OFF_W-1:0]  sp_first, sp_last;
    logic [PG_W-1:0]   sp_page;
    logic [SKIP_W-1:0] sp_skip;
    ldr_kind_t         kind_c;
    logic [COL_W-1:0]  col_c;

    ldr_span #(
        .OFF_W(OFF_W), .PAGE_BYTES(PAGE_BYTES), .BLK_BYTES(BLK_BYTES),
        .PG_W(PG_W), .SKIP_W(SKIP_W)
    ) u_span (
        .offset(start_offset), .length(start_len),
        .first_blk(sp_first), .last_blk(sp_last),
        .first_page(sp_page), .lead_skip(sp_skip)
    );

    ldr_colgen #(
        .PAGE_BYTES(PAGE_BYTES), .ECC_STEP(ECC_STEP), .ECC_BYTES(ECC_BYTES),
        .ECC_POS(ECC_POS), .MARK_POS(MARK_POS), .STEP_W(STEP_W), .COL_W(COL_W)
    ) u_col (
        .kind(kind_c), .step(r_q.step), .col(col_c)
    );

    always_comb begin
        unique case (r_q.st)
            S_MARK_CMD: kind_c = K_MARK;
            S_OPEN_CMD: kind_c = K_OPEN;
            S_DCOL_CMD: kind_c = K_DATA;
            default:    kind_c = K_ECC;
        endcase
    end

    always_comb begin
        r_d       = r_q;
        r_d.wr_v  = 1'b0;
        r_d.ecc_v = 1'b0;
        r_d.done  = 1'b0;
        unique case (r_q.st)
            S_IDLE: if (start) begin
                r_d.blk  = sp_first;
                r_d.last = sp_last;
                r_d.page = sp_page;
                r_d.skip = sp_skip;
                r_d.wptr = dst_base;
                r_d.st   = S_MARK_CMD;
            end
            S_MARK_CMD: if (cmd_done) r_d.st = S_MARK_BYTE;
            S_MARK_BYTE: if (rd_valid) begin
                if (rd_data == 8'hFF) begin
                    r_d.step = '0;
                    r_d.st   = S_OPEN_CMD;
                end else begin
                    r_d.last = r_q.last + OFF_W'(1);
                    r_d.st   = S_NEXT_BLK;
                end
            end
            S_OPEN_CMD: if (cmd_done) r_d.st = S_DCOL_CMD;
            S_DCOL_CMD: if (cmd_done) begin
                r_d.cnt = '0;
                r_d.st  = S_DATA;
            end
            S_DATA: if (rd_valid) begin
                if (r_q.skip != '0) begin
                    r_d.skip = r_q.skip - SKIP_W'(1);
                end else begin
                    r_d.wr_v = 1'b1;
                    r_d.wr_a = r_q.wptr;
                    r_d.wr_d = rd_data;
                    r_d.wptr = r_q.wptr + DST_W'(1);
                end
                r_d.cnt = r_q.cnt + CNT_W'(1);
                if (r_q.cnt == CNT_W'(ECC_STEP - 1)) r_d.st = S_ECOL_CMD;
            end
            S_ECOL_CMD: if (cmd_done) begin
                r_d.cnt = '0;
                r_d.st  = S_ECC;
            end
            S_ECC: if (rd_valid) begin
                r_d.ecc_v = 1'b1;
                r_d.ecc_s = r_q.step;
                r_d.ecc_d = rd_data;
                r_d.cnt   = r_q.cnt + CNT_W'(1);
                if (r_q.cnt == CNT_W'(ECC_BYTES - 1)) begin
                    if (r_q.step == STEP_W'(STEPS - 1)) begin
                        r_d.step = '0;
                        if (r_q.page == PG_W'(PAGES_PER_BLOCK - 1)) begin
                            r_d.page = '0;
                            r_d.st   = S_NEXT_BLK;
                        end else begin
                            r_d.page = r_q.page + PG_W'(1);
                            r_d.st   = S_OPEN_CMD;
                        end
                    end else begin
                        r_d.step = r_q.step + STEP_W'(1);
                        r_d.st   = S_DCOL_CMD;
                    end
                end
            end
            S_NEXT_BLK: begin
                if (r_q.blk >= r_q.last) begin
                    r_d.done = 1'b1;
                    r_d.st   = S_IDLE;
                end else begin
                    r_d.blk = r_q.blk + OFF_W'(1);
                    r_d.st  = S_MARK_CMD;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st != S_IDLE);
    assign done      = r_q.done;
    assign cmd_req   = (r_q.st == S_MARK_CMD) || (r_q.st == S_OPEN_CMD) ||
                       (r_q.st == S_DCOL_CMD) || (r_q.st == S_ECOL_CMD);
    assign cmd_kind  = kind_c;
    assign cmd_block = r_q.blk;
    assign cmd_page  = (r_q.st == S_MARK_CMD) ? '0 : r_q.page;
    assign cmd_col   = col_c;
    assign wr_valid  = r_q.wr_v;
    assign wr_addr   = r_q.wr_a;
    assign wr_data   = r_q.wr_d;
    assign ecc_valid = r_q.ecc_v;
    assign ecc_step  = r_q.ecc_s;
    assign ecc_data  = r_q.ecc_d;

    // Checker state: last write address of the current load
    logic             chk_seen_q;
    logic [DST_W-1:0] chk_last_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_seen_q <= 1'b0;
            chk_last_q <= '0;
        end else if (start && !busy) begin
            chk_seen_q <= 1'b0;
        end else if (wr_valid) begin
            chk_seen_q <= 1'b1;
            chk_last_q <= wr_addr;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!cmd_req && !wr_valid));

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && !cmd_done) |=> (cmd_req && $stable(cmd_col) && $stable(cmd_kind)));

    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && ecc_valid));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_wr_contig_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && chk_seen_q) |-> (wr_addr == chk_last_q + DST_W'(1)));
endmodule

// File: tb/nand_image_loader_bench.sv
`timescale 1ns/1ps
module nand_image_loader_bench;
    localparam int OFF_W = 24;
    localparam int DST_W = 10;
    localparam int PAGE = 16;
    localparam int PPB = 4;
    localparam int BLK = PAGE * PPB;
    localparam int ESTEP = 8;
    localparam int EBYTES = 3;
    localparam int EPOS = 1;
    localparam int MPOS = 0;
    localparam int NSTEP = PAGE / ESTEP;

    typedef struct packed {
        logic [15:0] off;
        logic [15:0] len;
        logic [15:0] mask;
        logic [9:0]  base;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VEC [NVEC] = '{
        '{off: 16'd0,   len: 16'd64,  mask: 16'h0000, base: 10'd0},
        '{off: 16'd32,  len: 16'd40,  mask: 16'h0000, base: 10'd100},
        '{off: 16'd0,   len: 16'd128, mask: 16'h0002, base: 10'd200},
        '{off: 16'd70,  len: 16'd20,  mask: 16'h0002, base: 10'd400},
        '{off: 16'd100, len: 16'd10,  mask: 16'h0002, base: 10'd500},
        '{off: 16'd5,   len: 16'd200, mask: 16'h0009, base: 10'd600}
    };

    logic clk = 0;
    logic rst_n = 0;
    logic start = 0;
    logic [OFF_W-1:0] start_offset = '0;
    logic [OFF_W-1:0] start_len = '0;
    logic [DST_W-1:0] dst_base = '0;
    logic busy, done, cmd_req, cmd_done, rd_valid;
    logic [1:0] cmd_kind;
    logic [OFF_W-1:0] cmd_block;
    logic [1:0] cmd_page;
    logic [4:0] cmd_col;
    logic [7:0] rd_data;
    logic wr_valid, ecc_valid;
    logic [DST_W-1:0] wr_addr;
    logic [7:0] wr_data, ecc_data;
    logic [0:0] ecc_step;

    always #4 clk = ~clk;

    nand_image_loader #(
        .OFF_W(OFF_W), .DST_W(DST_W), .PAGE_BYTES(PAGE), .SPARE_BYTES(8),
        .PAGES_PER_BLOCK(PPB), .ECC_STEP(ESTEP), .ECC_BYTES(EBYTES),
        .ECC_POS(EPOS), .MARK_POS(MPOS)
    ) u_nand_image_loader (
        .clk(clk), .rst_n(rst_n), .start(start), .start_offset(start_offset),
        .start_len(start_len), .dst_base(dst_base), .busy(busy), .done(done),
        .cmd_req(cmd_req), .cmd_kind(cmd_kind), .cmd_block(cmd_block),
        .cmd_page(cmd_page), .cmd_col(cmd_col), .cmd_done(cmd_done),
        .rd_valid(rd_valid), .rd_data(rd_data), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .ecc_valid(ecc_valid),
        .ecc_step(ecc_step), .ecc_data(ecc_data)
    );

    int checks = 0;
    int errors = 0;
    logic [15:0] cur_mask = '0;
    logic [7:0] exp_mem [1024];
    bit exp_have [1024];
    bit got [1024];
    int n_exp, n_ecc_exp, n_wr, n_ecc;
    logic [7:0] ecc_q [$];
    int step_q [$];
    int rs_step = 0;

    function automatic logic [7:0] dbyte(int b, int p, int c);
        return 8'(b * 37 + p * 11 + c * 3 + 1);
    endfunction

    function automatic logic [7:0] ebyte(int b, int p, int c);
        return 8'(b * 13 + p * 7 + c * 5) ^ 8'h5A;
    endfunction

    function automatic bit is_bad(int b);
        return (b < 16) ? cur_mask[b] : 1'b0;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Expected image from the range rules (R3, R4, R5)
    task automatic build_exp(input int off, input int len, input int base);
        int first, last, pg, sk, addr;
        for (int i = 0; i < 1024; i++) begin
            exp_have[i] = 0;
            got[i] = 0;
        end
        first = off / BLK;
        last = (off + len - 1) / BLK;
        pg = (off % BLK) / PAGE;
        sk = off % PAGE;
        addr = base;
        n_exp = 0;
        n_ecc_exp = 0;
        for (int b = first; b <= last; b++) begin
            if (is_bad(b)) begin
                last++;
            end else begin
                for (int p = pg; p < PPB; p++) begin
                    for (int c = 0; c < PAGE; c++) begin
                        if (sk > 0) sk--;
                        else begin
                            exp_mem[addr] = dbyte(b, p, c);
                            exp_have[addr] = 1;
                            addr++;
                            n_exp++;
                        end
                    end
                    n_ecc_exp += NSTEP * EBYTES;
                end
                pg = 0;
            end
        end
    endtask

    // Flash engine model: answers commands, streams bytes with gaps
    initial begin
        int k, b, p, c, n;
        cmd_done = 0;
        rd_valid = 0;
        rd_data = '0;
        forever begin
            @(negedge clk);
            if (rst_n && cmd_req) begin
                k = int'(cmd_kind);
                b = int'(cmd_block);
                p = int'(cmd_page);
                c = int'(cmd_col);
                n = 0;
                case (k)
                    0: begin
                        chk(p == 0, "R2", "marker page", p, 0);
                        chk(c == PAGE + MPOS, "R2", "marker column", c, PAGE + MPOS);
                        n = 1;
                    end
                    1: begin
                        chk(c == 0, "R6", "open column", c, 0);
                        rs_step = 0;
                    end
                    2: begin
                        chk(c == rs_step * ESTEP, "R6", "data column", c, rs_step * ESTEP);
                        n = ESTEP;
                    end
                    default: begin
                        chk(c == PAGE + EPOS + rs_step * EBYTES, "R6", "ecc column",
                            c, PAGE + EPOS + rs_step * EBYTES);
                        n = EBYTES;
                    end
                endcase
                @(negedge clk);
                cmd_done = 1;
                @(negedge clk);
                cmd_done = 0;
                for (int i = 0; i < n; i++) begin
                    rd_valid = 1;
                    if (k == 0) rd_data = is_bad(b) ? 8'h00 : 8'hFF;
                    else if (k == 2) rd_data = dbyte(b, p, c + i);
                    else begin
                        rd_data = ebyte(b, p, c + i);
                        ecc_q.push_back(rd_data);
                        step_q.push_back(rs_step);
                    end
                    @(negedge clk);
                    rd_valid = 0;
                    if (i % 2 == 1) @(negedge clk);
                end
                if (k == 3) rs_step++;
            end
        end
    end

    // Output monitor
    initial begin
        logic [7:0] ed;
        int es;
        forever begin
            @(negedge clk);
            if (rst_n && wr_valid) begin
                n_wr++;
                chk(exp_have[wr_addr] && !got[wr_addr] && wr_data == exp_mem[wr_addr],
                    "R9", "write data at address", int'(wr_data), int'(exp_mem[wr_addr]));
                got[wr_addr] = 1;
            end
            if (rst_n && ecc_valid) begin
                n_ecc++;
                if (ecc_q.size() == 0) begin
                    chk(0, "R7", "unexpected ecc byte", int'(ecc_data), -1);
                end else begin
                    ed = ecc_q.pop_front();
                    es = step_q.pop_front();
                    chk(ecc_data == ed, "R7", "ecc byte", int'(ecc_data), int'(ed));
                    chk(int'(ecc_step) == es, "R7", "ecc step", int'(ecc_step), es);
                end
            end
        end
    end

    task automatic run_load(input int off, input int len, input int base, input logic [15:0] mask);
        int cyc, miss, bad_busy;
        cur_mask = mask;
        build_exp(off, len, base);
        n_wr = 0;
        n_ecc = 0;
        @(negedge clk);
        start_offset = OFF_W'(off);
        start_len = OFF_W'(len);
        dst_base = DST_W'(base);
        start = 1;
        @(negedge clk);
        start = 0;
        chk(busy == 1'b1, "R8", "busy after start", int'(busy), 1);
        cyc = 0;
        bad_busy = 0;
        while (!done && cyc < 20000) begin
            if (!busy) bad_busy++;
            @(negedge clk);
            cyc++;
        end
        chk(cyc < 20000, "R8", "done reached", cyc, 0);
        chk(busy == 1'b0, "R8", "busy low with done", int'(busy), 0);
        chk(bad_busy == 0, "R8", "busy gaps", bad_busy, 0);
        @(negedge clk);
        chk(done == 1'b0, "R8", "done single cycle", int'(done), 0);
        chk(n_wr == n_exp, "R3", "write count", n_wr, n_exp);
        miss = 0;
        for (int i = 0; i < 1024; i++) if (exp_have[i] && !got[i]) miss++;
        chk(miss == 0, "R4", "missing bytes", miss, 0);
        if (n_exp > 0)
            chk(got[base], "R5", "first byte at base", int'(got[base]), 1);
        chk(n_ecc == n_ecc_exp, "R7", "ecc byte count", n_ecc, n_ecc_exp);
    endtask

    initial begin
        #1600000;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(!busy && !done, "R1", "busy/done after reset", int'(busy) + int'(done), 0);
        chk(!cmd_req && !wr_valid && !ecc_valid, "R1", "strobes after reset",
            int'(cmd_req) + int'(wr_valid) + int'(ecc_valid), 0);

        for (int v = 0; v < NVEC; v++) begin
            run_load(int'(VEC[v].off), int'(VEC[v].len), int'(VEC[v].base), VEC[v].mask);
        end

        // R4 boundary: one byte in the last page of a block
        run_load(48, 1, 900, 16'h0000);
        chk(n_wr == 16, "R4", "last-page single byte load", n_wr, 16);

        // R1: idle again, nothing issued
        repeat (5) @(negedge clk);
        chk(!cmd_req && !wr_valid && !busy, "R1", "quiet when idle",
            int'(cmd_req) + int'(wr_valid) + int'(busy), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule